// File: doc/BRIEF.md
# Legacy Interrupt Status Register

This block holds an 8-bit, sticky interrupt cause register for a device that signals the host through a level-sensitive legacy interrupt pin. The device core raises single-cycle pulses when a virtqueue needs service or when its configuration has changed. Each pulse latches a cause bit. A single-byte read by the driver returns the latched causes and empties the register in the same access. Emptying the register drops the pin.

Two configuration-space bits shape the behaviour. When message-signalled interrupts are enabled, queue pulses are not recorded and the legacy outputs stay low. In that mode queue notifications travel by message, and the message generator lies outside this block. The legacy interrupt-disable bit masks only the pin. It does not mask the status output or the latched causes.

Top module: `irq_stat_intx`

## Requirements
- R1: After reset the register holds 0, a read returns 0x00, and both `irq_stat_o` and `intx_o` are low.
- R2: With `msix_en_i` low, a pulse on `q_evt_i` sets bit 0 (value 0x01), and a later read returns it.
- R3: A pulse on `cfg_evt_i` sets bit 1 (value 0x02), whatever the state of `msix_en_i`.
- R4: While `rd_i` is high, `rd_data_o` shows the register value held in that cycle. The register reads as 0 from the next cycle on, unless a new event arrived (see R5).
- R5: An event arriving in the same cycle as a read is not returned by that read. It is held in the register after the clear.
- R6: With `msix_en_i` high, a pulse on `q_evt_i` leaves bit 0 clear.
- R7: `irq_stat_o` is high exactly when `msix_en_i` is low and any register bit is set.
- R8: `intx_o` equals `irq_stat_o` while `intx_dis_i` is low, and is low while `intx_dis_i` is high. Masking the pin does not clear the register.
- R9: Bits 7 down to 2 always read 0.
- R10: Set bits stay set across later events until a read clears them, so several events read back as their OR (for example 0x03).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_evt_i | input | 1 | Queue event pulse from the device core |
| cfg_evt_i | input | 1 | Configuration-change event pulse |
| msix_en_i | input | 1 | Message-signalled interrupts enabled |
| intx_dis_i | input | 1 | Legacy interrupt-disable bit |
| rd_i | input | 1 | Driver read strobe, one cycle per access |
| rd_data_o | output | 8 | Register value returned by the read, 0 when idle |
| irq_stat_o | output | 1 | Interrupt status: OR of the register bits |
| intx_o | output | 1 | Level-sensitive legacy interrupt pin |

## Verification
The main corner case is a configuration event that arrives in the same cycle as a read. A design that clears after the merge loses the event. A design that merges before the capture hands the event to the read that should not see it. The bench also raises queue events while message signalling is on: a design that routes them anyway reads back 0x01 and drives the pin. With the disable bit set, a design that gates the register instead of the pin loses the pending cause once the mask is lifted. Accumulated events must read back as 0x03 with zero reserved bits. This shows whether a design overwrites the register instead of ORing into it.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned QBIT = 0;
  localparam int unsigned CBIT = 1;

  // Next register value: a read clears old contents, new causes always merge in.
  function automatic logic [7:0] isr_next(input logic [7:0] cur, input logic [7:0] setv,
                                          input logic rd);
    return (rd ? 8'h00 : cur) | setv;
  endfunction
endpackage

// File: rtl/isr_route.sv
module isr_route #(
  parameter int unsigned W = 8
) (
  input  logic         q_evt,
  input  logic         cfg_evt,
  input  logic         msix_en,
  output logic [W-1:0] set_vec
);
  import isr_pkg::*;

  always_comb begin
    set_vec       = '0;
    set_vec[QBIT] = q_evt & ~msix_en;
    set_vec[CBIT] = cfg_evt;
  end
endmodule

// File: rtl/isr_store.sv
module isr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         rd,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] rd_data
);
  import isr_pkg::*;
  localparam logic [W-1:0] USED = (W'(1) << QBIT) | (W'(1) << CBIT);

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= W'(isr_next(8'(stat_q), 8'(set_vec), rd));
  end

  assign rd_data = rd ? stat_q : '0;

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && set_vec == '0) |=> stat_q == '0); // R4
  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec))); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~USED) == '0); // R9
endmodule

// File: rtl/isr_pin.sv
module isr_pin #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] stat,
  input  logic         msix_en,
  input  logic         intx_dis,
  output logic         irq_stat,
  output logic         intx
);
  assign irq_stat = (|stat) & ~msix_en;
  assign intx     = irq_stat & ~intx_dis;
endmodule

// File: rtl/irq_stat_intx.sv
module irq_stat_intx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       q_evt_i,
  input  logic       cfg_evt_i,
  input  logic       msix_en_i,
  input  logic       intx_dis_i,
  input  logic       rd_i,
  output logic [7:0] rd_data_o,
  output logic       irq_stat_o,
  output logic       intx_o
);
  import isr_pkg::*;
  localparam int unsigned W = 8;

  logic [W-1:0] set_w;
  logic [W-1:0] stat_w;

  isr_route #(.W(W)) u_route (
    .q_evt(q_evt_i), .cfg_evt(cfg_evt_i), .msix_en(msix_en_i), .set_vec(set_w)
  );

  isr_store #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .set_vec(set_w), .rd(rd_i),
    .stat_q(stat_w), .rd_data(rd_data_o)
  );

  isr_pin #(.W(W)) u_pin (
    .stat(stat_w), .msix_en(msix_en_i), .intx_dis(intx_dis_i),
    .irq_stat(irq_stat_o), .intx(intx_o)
  );

  AST_MSIX_NO_Q: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && msix_en_i) |=> !stat_w[QBIT]); // R6
  AST_STAT_OR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat_o |-> (stat_w != '0)); // R7
  AST_PIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    intx_o |-> (!intx_dis_i && !msix_en_i)); // R8
  AST_CFG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_evt_i |=> stat_w[CBIT]); // R3
endmodule

// File: tb/irq_stat_intx_test.sv
module irq_stat_intx_test;
  logic clk = 0;
  logic rst_n = 0;
  logic q_evt = 0, cfg_evt = 0, msix_en = 0, intx_dis = 0, rd = 0;
  logic [7:0] rd_data;
  logic irq_stat, intx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_stat_intx uut (
    .clk(clk), .rst_n(rst_n), .q_evt_i(q_evt), .cfg_evt_i(cfg_evt),
    .msix_en_i(msix_en), .intx_dis_i(intx_dis), .rd_i(rd),
    .rd_data_o(rd_data), .irq_stat_o(irq_stat), .intx_o(intx)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic q, input logic c);
    @(negedge clk); q_evt = q; cfg_evt = c;
    @(negedge clk); q_evt = 0; cfg_evt = 0;
    #1;
  endtask

  task automatic do_read(output logic [7:0] d);
    @(negedge clk); rd = 1; #1 d = rd_data;
    @(negedge clk); rd = 0; #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq_stat", 8'(irq_stat), 8'h0);
    chk("R1 intx", 8'(intx), 8'h0);
    do_read(d); chk("R1 read", d, 8'h00);
  endtask

  task automatic t_queue();
    logic [7:0] d;
    msix_en = 0; intx_dis = 0;
    pulse(1, 0);
    chk("R7 irq_stat set", 8'(irq_stat), 8'h1);
    chk("R8 intx follows", 8'(intx), 8'h1);
    do_read(d); chk("R2 queue bit", d, 8'h01);
    chk("R4 irq after read", 8'(irq_stat), 8'h0);
    chk("R4 intx after read", 8'(intx), 8'h0);
    do_read(d); chk("R4 cleared", d, 8'h00);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    msix_en = 1;
    pulse(0, 1);
    chk("R7 irq off under msix", 8'(irq_stat), 8'h0);
    do_read(d); chk("R3 cfg bit msix on", d, 8'h02);
    msix_en = 0;
    pulse(0, 1);
    do_read(d); chk("R3 cfg bit msix off", d, 8'h02);
  endtask

  task automatic t_msix();
    logic [7:0] d;
    msix_en = 1;
    pulse(1, 0);
    chk("R6 intx low", 8'(intx), 8'h0);
    do_read(d); chk("R6 queue ignored", d, 8'h00);
    msix_en = 0;
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pulse(1, 0);
    @(negedge clk); rd = 1; cfg_evt = 1; #1 d = rd_data;
    chk("R5 read excludes new event", d, 8'h01);
    @(negedge clk); rd = 0; cfg_evt = 0; #1;
    chk("R5 irq still set", 8'(irq_stat), 8'h1);
    do_read(d); chk("R5 event kept", d, 8'h02);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    intx_dis = 1;
    pulse(1, 0);
    chk("R8 status unmasked", 8'(irq_stat), 8'h1);
    chk("R8 pin masked", 8'(intx), 8'h0);
    @(negedge clk); intx_dis = 0; #1;
    chk("R8 pin after unmask", 8'(intx), 8'h1);
    do_read(d); chk("R8 mask kept cause", d, 8'h01);
  endtask

  task automatic t_accum();
    logic [7:0] d;
    pulse(1, 0); pulse(0, 1); pulse(1, 0);
    do_read(d);
    chk("R10 accumulated", d, 8'h03);
    chk("R9 reserved zero", d & 8'hFC, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_queue();
    t_cfg();
    t_msix();
    t_collide();
    t_mask();
    t_accum();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule